// File: doc/BRIEF.md
# Infrared receiver activity and status

This block sits behind a sampled consumer-infrared input. While the receiver is idle it counts consecutive samples at the active line level and declares the receiver busy once that run reaches a programmable threshold. The threshold counts either single sample ticks or groups of 128 ticks. While busy it measures how long the line stays at each level. It packs every finished run into a byte, with the line level in bit 7 and the length in sample ticks in bits 6:0, and pushes that byte into a 64-entry receive FIFO. A long stretch at the idle level ends reception and returns the receiver to idle.

Software reads the FIFO through a valid/ready stream. `rd_valid` is high whenever at least one byte is stored, and `rd_data` shows the oldest byte. A byte leaves the FIFO on a clock edge where both `rd_valid` and `rd_ready` are high. While `rd_ready` is low, the head byte and its valid stay put, and the producer side never stalls. When the FIFO is full, new bytes are dropped and an overrun is flagged.

Three sticky flags are kept: overrun (bit 0), packet end (bit 1) and FIFO-level reached (bit 2). The clear mask and the interrupt-enable vector use the same bit positions. Each flag is cleared by writing a 1 to its bit, and the interrupt line is the enabled OR of the flags.

Top module: `ir_rx_activity`

## Requirements
- R1: After reset, `busy`, `fifo_count`, `flags`, `irq` and `rd_valid` are all 0.
- R2: With `thresh_unit`=0, `busy` rises on the sample tick (`samp_en`=1) on which the number of consecutive samples with `ir_in`=1 (the active level) reaches `act_thresh`. A threshold of 0 acts as 1. Any sample with `ir_in`=0 restarts the count, and `busy` changes only on sample ticks.
- R3: With `thresh_unit`=1, the required number of consecutive active samples is `act_thresh`×128.
- R4: While busy, each change of `ir_in` between two sample ticks pushes one byte. Bit 7 of the byte is the level just ended, and bits 6:0 are its length in ticks. A run of length 0 is never pushed. The run that is open when the receiver turns busy is at level 1 and has length 0.
- R5: A run that reaches 127 ticks is pushed at once as level plus 127 (8'hFF for level 1). Its length then restarts at 0.
- R6: While busy, the idle-level sample on which the count of consecutive idle samples goes past `IDLE_TO` does three things. It pushes the open idle run, including that sample. It drops `busy` to 0. It sets `flags[1]` (packet end).
- R7: `fifo_count` ranges from 0 to 64, and `rd_valid` is high exactly when it is non-zero. Bytes come out in push order. While `rd_ready` is low, `rd_data` holds steady.
- R8: A byte pushed while 64 bytes are stored is dropped and sets `flags[0]` (overrun). The stored bytes are unchanged.
- R9: When `fifo_level` is non-zero and `fifo_count` ≥ `fifo_level`, `flags[2]` is set on the next clock edge. Below that level it is not set.
- R10: A cycle with `clr_we`=1 clears each flag whose `clr_mask` bit is 1. Mask bits of 0 leave their flag unchanged. If a flag's set condition holds in the same cycle, the flag stays set.
- R11: `irq` is high exactly when some bit of `flags & irq_en` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| samp_en | input | 1 | Sample tick enable |
| ir_in | input | 1 | IR line, synchronous to clk, idle level 0 |
| act_thresh | input | 7 | Active run threshold |
| thresh_unit | input | 1 | Threshold unit: 0 = one tick, 1 = 128 ticks |
| fifo_level | input | 7 | FIFO level for flag bit 2 (0 disables) |
| irq_en | input | 3 | Interrupt enable per flag |
| clr_we | input | 1 | Flag clear write strobe |
| clr_mask | input | 3 | Write-one-to-clear mask |
| rd_valid | output | 1 | FIFO head byte valid |
| rd_ready | input | 1 | Consumer accepts head byte |
| rd_data | output | 8 | FIFO head byte: level in bit 7, length in bits 6:0 |
| fifo_count | output | 7 | Bytes stored, 0 to 64 |
| busy | output | 1 | 0 idle, 1 receiving |
| flags | output | 3 | Sticky flags: overrun, packet end, level reached |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume the following about the inputs:
- `ir_in` is already synchronous to `clk` and is looked at only on `samp_en` cycles.
- `IDLE_TO` is at least 1, so the sample that triggers a timeout always continues an idle run.
- The threshold inputs do not change while a threshold count is in progress.

The stimulus keeps to these assumptions in three ways. It drives every input one nanosecond after a rising edge. It puts an idle cycle between any two sample ticks. It changes the threshold settings only while the receiver is idle and the line has been at 0.

// File: rtl/ir_rx_pkg.sv
package ir_rx_pkg;
  localparam int FLAG_OVR = 0;
  localparam int FLAG_PKT = 1;
  localparam int FLAG_AVL = 2;
  localparam int NFLAGS   = 3;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_BUSY = 1'b1
  } rx_state_e;
endpackage

// File: rtl/ir_act_detect.sv
module ir_act_detect
  import ir_rx_pkg::*;
#(
  parameter int   RUN_W    = 7,
  parameter int   THR_W    = 7,
  parameter int   UNIT_SH  = 7,
  parameter int   IDLE_TO  = 200,
  parameter logic IDLE_LVL = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             samp_en,
  input  logic             ir_in,
  input  logic [THR_W-1:0] act_thresh,
  input  logic             thresh_unit,
  output logic             busy,
  output logic             push,
  output logic [RUN_W:0]   push_data,
  output logic             pkt_done
);
  localparam int ACT_W = THR_W + UNIT_SH;
  localparam int IDL_W = $clog2(IDLE_TO + 1);
  localparam logic [RUN_W-1:0] RUN_MAX = '1;

  rx_state_e        state, state_n;
  logic [ACT_W-1:0] act_cnt, act_n, target, eff, act_inc;
  logic             cur_pol, pol_n, line_act;
  logic [RUN_W-1:0] run_len, len_n, run_inc;
  logic [IDL_W-1:0] idle_cnt, idle_n;

  assign line_act = (ir_in != IDLE_LVL);
  assign target   = thresh_unit ? {act_thresh, {UNIT_SH{1'b0}}} : ACT_W'(act_thresh);
  assign eff      = (target == '0) ? ACT_W'(1) : target;
  assign act_inc  = act_cnt + 1'b1;
  assign run_inc  = run_len + 1'b1;
  assign busy     = (state == ST_BUSY);

  always_comb begin
    state_n   = state;
    act_n     = act_cnt;
    pol_n     = cur_pol;
    len_n     = run_len;
    idle_n    = idle_cnt;
    push      = 1'b0;
    push_data = '0;
    pkt_done  = 1'b0;
    if (samp_en) begin
      case (state)
        ST_IDLE: begin
          if (line_act) begin
            if (act_inc >= eff) begin
              state_n = ST_BUSY;
              act_n   = '0;
              pol_n   = ~IDLE_LVL;
              len_n   = '0;
              idle_n  = '0;
            end else begin
              act_n = act_inc;
            end
          end else begin
            act_n = '0;
          end
        end
        default: begin
          idle_n = line_act ? '0 : idle_cnt + 1'b1;
          if (!line_act && idle_cnt == IDL_W'(IDLE_TO)) begin
            // idle run went past the timeout: flush it and leave
            push      = 1'b1;
            push_data = {ir_in, run_inc};
            pkt_done  = 1'b1;
            state_n   = ST_IDLE;
            len_n     = '0;
            idle_n    = '0;
            act_n     = '0;
          end else if (ir_in == cur_pol) begin
            if (run_inc == RUN_MAX) begin
              push      = 1'b1;
              push_data = {cur_pol, RUN_MAX};
              len_n     = '0;
            end else begin
              len_n = run_inc;
            end
          end else begin
            if (run_len != '0) begin
              push      = 1'b1;
              push_data = {cur_pol, run_len};
            end
            pol_n = ir_in;
            len_n = RUN_W'(1);
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      act_cnt  <= '0;
      cur_pol  <= IDLE_LVL;
      run_len  <= '0;
      idle_cnt <= '0;
    end else begin
      state    <= state_n;
      act_cnt  <= act_n;
      cur_pol  <= pol_n;
      run_len  <= len_n;
      idle_cnt <= idle_n;
    end
  end

  assert_busy_on_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !samp_en |=> $stable(busy));
  assert_nonzero_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (push_data[RUN_W-1:0] != '0));
  assert_push_when_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> busy);
  assert_exit_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_done |=> !busy);
endmodule

// File: rtl/ir_rx_fifo.sv
module ir_rx_fifo #(
  parameter int DEPTH = 64,
  parameter int W     = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  push_data,
  input  logic          out_ready,
  output logic          out_valid,
  output logic [W-1:0]  out_data,
  output logic [CW-1:0] count,
  output logic          overflow
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic          full, wr, rd;

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full      = (count == CW'(DEPTH));
  assign out_valid = (count != '0);
  assign wr        = push && !full;
  assign rd        = out_valid && out_ready;
  assign overflow  = push && full;
  assign out_data  = mem[rptr];

  always_ff @(posedge clk) begin
    if (wr) mem[wptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (wr) wptr <= step(wptr);
      if (rd) rptr <= step(rptr);
      count <= count + CW'(wr) - CW'(rd);
    end
  end

  assert_count_max_R7: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
  assert_head_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
  assert_full_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !out_ready) |=> (count == CW'(DEPTH)));
endmodule

// File: rtl/ir_rx_status.sv
module ir_rx_status
  import ir_rx_pkg::*;
#(
  parameter int CW = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_ovr,
  input  logic              set_pkt,
  input  logic [CW-1:0]     count,
  input  logic [CW-1:0]     level,
  input  logic              clr_we,
  input  logic [NFLAGS-1:0] clr_mask,
  input  logic [NFLAGS-1:0] irq_en,
  output logic [NFLAGS-1:0] flags,
  output logic              irq
);
  logic [NFLAGS-1:0] set;

  always_comb begin
    set           = '0;
    set[FLAG_OVR] = set_ovr;
    set[FLAG_PKT] = set_pkt;
    set[FLAG_AVL] = (level != '0) && (count >= level);
  end

  for (genvar i = 0; i < NFLAGS; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rst_n)                     flags[i] <= 1'b0;
      else if (set[i])                flags[i] <= 1'b1;
      else if (clr_we && clr_mask[i]) flags[i] <= 1'b0;
    end

    assert_w1c_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_we && clr_mask[i] && !set[i]) |=> !flags[i]);
    assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
      set[i] |=> flags[i]);
  end

  assign irq = |(flags & irq_en);
endmodule

// File: rtl/ir_rx_activity.sv
module ir_rx_activity
  import ir_rx_pkg::*;
#(
  parameter int   DEPTH    = 64,
  parameter int   RUN_W    = 7,
  parameter int   THR_W    = 7,
  parameter int   UNIT_SH  = 7,
  parameter int   IDLE_TO  = 200,
  parameter logic IDLE_LVL = 1'b0,
  localparam int  CW       = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              samp_en,
  input  logic              ir_in,
  input  logic [THR_W-1:0]  act_thresh,
  input  logic              thresh_unit,
  input  logic [CW-1:0]     fifo_level,
  input  logic [NFLAGS-1:0] irq_en,
  input  logic              clr_we,
  input  logic [NFLAGS-1:0] clr_mask,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [RUN_W:0]    rd_data,
  output logic [CW-1:0]     fifo_count,
  output logic              busy,
  output logic [NFLAGS-1:0] flags,
  output logic              irq
);
  logic           push, pkt_done, overflow;
  logic [RUN_W:0] push_data;

  ir_act_detect #(
    .RUN_W(RUN_W), .THR_W(THR_W), .UNIT_SH(UNIT_SH),
    .IDLE_TO(IDLE_TO), .IDLE_LVL(IDLE_LVL)
  ) u_det (
    .clk(clk), .rst_n(rst_n), .samp_en(samp_en), .ir_in(ir_in),
    .act_thresh(act_thresh), .thresh_unit(thresh_unit),
    .busy(busy), .push(push), .push_data(push_data), .pkt_done(pkt_done)
  );

  ir_rx_fifo #(.DEPTH(DEPTH), .W(RUN_W + 1)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(push), .push_data(push_data),
    .out_ready(rd_ready), .out_valid(rd_valid), .out_data(rd_data),
    .count(fifo_count), .overflow(overflow)
  );

  ir_rx_status #(.CW(CW)) u_stat (
    .clk(clk), .rst_n(rst_n), .set_ovr(overflow), .set_pkt(pkt_done),
    .count(fifo_count), .level(fifo_level), .clr_we(clr_we),
    .clr_mask(clr_mask), .irq_en(irq_en), .flags(flags), .irq(irq)
  );

  assert_irq_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (flags == '0) |-> !irq);
endmodule

// File: tb/sim_ir_rx_activity.sv
`timescale 1ns/1ps
module sim_ir_rx_activity;
  localparam int TO = 40;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       samp_en = 1'b0, ir_in = 1'b0, thresh_unit = 1'b0;
  logic [6:0] act_thresh = '0, fifo_level = '0;
  logic [2:0] irq_en = 3'b111, clr_mask = '0, flags;
  logic       clr_we = 1'b0, rd_ready = 1'b1;
  logic       rd_valid, busy, irq;
  logic [7:0] rd_data;
  logic [6:0] fifo_count;

  int checks = 0, errors = 0, n_pop = 0;
  bit done = 0;
  logic [7:0] last_byte = '0;
  logic [7:0] q[$];

  // reference state
  bit m_busy = 0, m_pol = 0;
  int m_act = 0, m_len = 0, m_idle = 0;

  always #4 clk = ~clk;

  ir_rx_activity #(.IDLE_TO(TO)) u0 (
    .clk(clk), .rst_n(rst_n), .samp_en(samp_en), .ir_in(ir_in),
    .act_thresh(act_thresh), .thresh_unit(thresh_unit), .fifo_level(fifo_level),
    .irq_en(irq_en), .clr_we(clr_we), .clr_mask(clr_mask),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
    .fifo_count(fifo_count), .busy(busy), .flags(flags), .irq(irq)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic emit(input bit pol, input int len);
    if (!rd_ready && q.size() == 64) return;
    q.push_back({pol, 7'(len)});
  endtask

  task automatic model_step(input bit v);
    int eff;
    eff = thresh_unit ? act_thresh * 128 : act_thresh;
    if (eff == 0) eff = 1;
    if (!m_busy) begin
      if (v) begin
        m_act++;
        if (m_act >= eff) begin
          m_busy = 1; m_act = 0; m_pol = 1; m_len = 0; m_idle = 0;
        end
      end else m_act = 0;
    end else if (!v && m_idle == TO) begin
      emit(v, m_len + 1);
      m_busy = 0; m_len = 0; m_idle = 0; m_act = 0;
    end else begin
      m_idle = v ? 0 : m_idle + 1;
      if (v == m_pol) begin
        m_len++;
        if (m_len == 127) begin emit(m_pol, 127); m_len = 0; end
      end else begin
        if (m_len != 0) emit(m_pol, m_len);
        m_pol = v; m_len = 1;
      end
    end
  endtask

  // driver: one sample tick followed by one quiet cycle
  task automatic tick(input bit v);
    @(posedge clk); #1; samp_en = 1'b1; ir_in = v;
    @(posedge clk); #1; samp_en = 1'b0;
    model_step(v);
  endtask

  task automatic ticks(input bit v, input int n);
    for (int i = 0; i < n; i++) tick(v);
  endtask

  task automatic to_idle();
    for (int i = 0; i < 200 && m_busy; i++) tick(1'b0);
  endtask

  task automatic wclr(input logic [2:0] m);
    @(posedge clk); #1; clr_we = 1'b1; clr_mask = m;
    @(posedge clk); #1; clr_we = 1'b0; clr_mask = '0;
  endtask

  task automatic idle_cycles(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // monitor: scoreboard compare of every byte leaving the FIFO
  always @(negedge clk) begin
    if (rst_n && rd_valid && rd_ready) begin
      if (q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R7 unexpected byte actual=%0d expected=none", rd_data);
      end else begin
        chk("R4 byte order/content", rd_data, q.pop_front());
        last_byte = rd_data;
        n_pop++;
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    finish_run();
  end

  initial begin
    int base;
    idle_cycles(5);
    rst_n = 1'b1;
    idle_cycles(1);
    // R1
    chk("R1 busy", busy, 0);
    chk("R1 fifo_count", fifo_count, 0);
    chk("R1 flags", flags, 0);
    chk("R1 irq", irq, 0);
    chk("R1 rd_valid", rd_valid, 0);

    // R2: threshold 3 in single ticks, broken by an idle sample
    act_thresh = 7'd3; thresh_unit = 1'b0;
    ticks(1, 2); tick(0);
    chk("R2 restart after idle sample", busy, 0);
    ticks(1, 2);
    chk("R2 below threshold", busy, 0);
    tick(1);
    chk("R2 busy at threshold", busy, 1);
    ticks(1, 2); ticks(0, 5); ticks(1, 3); ticks(0, 2); ticks(1, 1);
    to_idle();
    chk("R6 busy falls after timeout", busy, 0);
    chk("R6 packet end flag", flags[1], 1);
    chk("R11 irq with flag enabled", irq, 1);
    idle_cycles(4);
    chk("R4 all expected bytes seen", q.size(), 0);

    // R10 / R11
    wclr(3'b000);
    chk("R10 zero mask keeps flag", flags[1], 1);
    irq_en = 3'b101; idle_cycles(1);
    chk("R11 irq masked", irq, 0);
    irq_en = 3'b111; idle_cycles(1);
    chk("R11 irq re-enabled", irq, 1);
    wclr(3'b010);
    chk("R10 write one clears", flags[1], 0);
    chk("R11 irq after clear", irq, 0);

    // R5: long mark, zero threshold
    act_thresh = 7'd0;
    tick(1);
    chk("R2 zero threshold acts as one", busy, 1);
    base = n_pop;
    ticks(1, 127);
    @(negedge clk); #1;
    chk("R5 one byte at 127", n_pop - base, 1);
    chk("R5 byte value", last_byte, 8'hFF);
    ticks(1, 173);
    to_idle();
    idle_cycles(4);
    chk("R5 split runs drained", q.size(), 0);
    wclr(3'b010);

    // R3: 128-tick unit, threshold 1
    act_thresh = 7'd1; thresh_unit = 1'b1;
    ticks(1, 127);
    chk("R3 127 ticks not enough", busy, 0);
    tick(1);
    chk("R3 busy at 128", busy, 1);
    ticks(0, 3); ticks(1, 9);
    to_idle();
    idle_cycles(4);
    chk("R3 bytes drained", q.size(), 0);
    wclr(3'b010);

    // R7 / R8 / R9: stall the consumer and overfill
    act_thresh = 7'd0; thresh_unit = 1'b0;
    fifo_level = 7'd10;
    @(posedge clk); #1; rd_ready = 1'b0;
    tick(1);
    for (int i = 0; i < 400 && q.size() < 9; i++) tick(i[0] ? 1'b1 : 1'b0);
    idle_cycles(1);
    chk("R7 count tracks stored bytes", fifo_count, 9);
    chk("R9 below level", flags[2], 0);
    tick(m_pol ? 1'b0 : 1'b1);
    idle_cycles(1);
    chk("R9 level reached", flags[2], 1);
    chk("R7 valid while stored", rd_valid, 1);
    chk("R7 head held while stalled", rd_data, q[0]);
    for (int i = 0; i < 400 && q.size() < 64; i++) tick(m_pol ? 1'b0 : 1'b1);
    chk("R8 no overrun before full", flags[0], 0);
    for (int i = 0; i < 6; i++) tick(m_pol ? 1'b0 : 1'b1);
    chk("R8 count capped", fifo_count, 64);
    chk("R8 overrun flag", flags[0], 1);
    wclr(3'b100);
    chk("R10 set wins over clear", flags[2], 1);
    wclr(3'b001);
    chk("R10 overrun cleared", flags[0], 0);
    @(posedge clk); #1; rd_ready = 1'b1;
    idle_cycles(80);
    chk("R8 stored bytes all matched", q.size(), 0);
    chk("R7 drained count", fifo_count, 0);
    chk("R7 valid low when empty", rd_valid, 0);
    to_idle();
    idle_cycles(4);
    chk("R6 final idle", busy, 0);
    chk("R4 nothing left", q.size(), 0);
    finish_run();
  end
endmodule